// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause-22 style management transactions to an Ethernet PHY over the two-wire MDC/MDIO link. A host programs it through a small register slave port. It writes a packed PHY/register selector and, for writes, a 16-bit data word. It then raises a level command bit. The controller derives MDC from the system clock through a programmable divider and shifts out a 64-bit management frame. For reads it releases MDIO at the turnaround and captures the PHY's reply into a read-data register.

The host sees the transaction through a busy flag in the command register. It waits for that flag to fall and then drops the command bit. A new transaction can only follow a fresh 0-to-1 edge of the command bit. The address and write data are latched when the transaction starts, so they must be programmed before the command bit is raised.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register offsets are 0x7C (config: MDC divider select in bits [5:2], reset value 0xD), 0x80 (command: bit 0 start, bit 1 = 1 for write and 0 for read, bit 2 busy read-only), 0x84 (PHY address in [12:8], register number in [4:0]), 0x88 (write data [15:0]) and 0x8C (read data [15:0], reset 0). Unused bits read as 0.
- R2: A transaction starts only on a 0-to-1 change of command bit 0 while idle. A rise during a transaction, or holding the bit high after completion, starts nothing.
- R3: MDC is low while idle. During a transaction its period is 2*(sel+1) system clock cycles, where sel is the divider select.
- R4: A write frame, first bit first, is 32 ones, 01, 01, PHY address (5 bits, MSB first), register number (5 bits), 10, then the 16 write-data bits MSB first. MDIO is driven for all 64 bits.
- R5: A read frame carries the same fields with opcode 10. MDIO output enable is low from bit 46 (the turnaround) through bit 63.
- R6: On a read, MDIO is sampled on each rising MDC edge of bits 48..63, MSB first, and the word appears in the read-data register after completion. A write leaves that register unchanged.
- R7: The busy bit is high from the start of a transaction until the last data bit has been shifted, and low otherwise.
- R8: MDIO data and output enable change only while MDC is low, never during an MDC high phase.
- R9: Each transaction produces exactly 64 rising MDC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The divider assertion assumes the divider select is not rewritten while a transaction is running. The bench programs the config, address and write-data registers only while the busy bit reads low. The sampling path assumes mdio_i has settled before each rising MDC edge. The bench PHY model therefore changes mdio_i only on falling MDC edges. Command toggling during a transaction is done deliberately, to show that it is ignored, and never alters the other registers mid-frame.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam logic [7:0] OFS_CFG = 8'h7C;
  localparam logic [7:0] OFS_CMD = 8'h80;
  localparam logic [7:0] OFS_ADR = 8'h84;
  localparam logic [7:0] OFS_WDT = 8'h88;
  localparam logic [7:0] OFS_RDT = 8'h8C;

  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned FIELD_W   = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FRAME_LEN = PRE_LEN + 4 + 2*FIELD_W + 2 + DATA_W;
  localparam int unsigned TA_IDX    = PRE_LEN + 4 + 2*FIELD_W;
  localparam int unsigned DAT_IDX   = TA_IDX + 2;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic               wr;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic [DATA_W-1:0]  wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
`timescale 1ns/1ps
module mdio_mgmt_clkgen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $stable(sel_i) |-> cnt_q <= sel_i); // R3
endmodule

// File: rtl/mdio_mgmt_frame.sv
`timescale 1ns/1ps
module mdio_mgmt_frame import mdio_mgmt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_req_t         req_i,
  input  logic              tick_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(TA_IDX);
  localparam logic [CNT_W-1:0] DAT_BIT  = CNT_W'(DAT_IDX);

  logic                 busy_q, mdc_q, wr_q, rdv_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] sh_q, frame_d;
  logic [DATA_W-1:0]    rsh_q;

  always_comb begin
    frame_d = {{PRE_LEN{1'b1}}, 2'b01,
               req_i.wr ? OP_WR : OP_RD,
               req_i.phy, req_i.regn,
               req_i.wr ? 2'b10 : 2'b11,
               req_i.wr ? req_i.wdata : {DATA_W{1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      wr_q   <= 1'b0;
      rdv_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rsh_q  <= '0;
    end else begin
      rdv_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
        wr_q   <= req_i.wr;
        sh_q   <= frame_d;
      end else if (busy_q && tick_i) begin
        if (!mdc_q) begin
          // rising MDC: sample reply bits
          mdc_q <= 1'b1;
          if (!wr_q && cnt_q >= DAT_BIT) rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
        end else begin
          // falling MDC: advance to next bit
          mdc_q <= 1'b0;
          if (cnt_q == LAST_BIT) begin
            busy_q <= 1'b0;
            rdv_q  <= !wr_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign mdc_o      = mdc_q;
  assign mdio_o     = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o  = busy_q && (wr_q || cnt_q < TA_BIT);
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rsh_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R2
  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_q && !mdio_oe_o); // R3
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_q |-> $stable(mdio_o) && $stable(mdio_oe_o)); // R8
  AST_BUSY_END_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !mdc_q && $past(cnt_q) == LAST_BIT); // R9
  AST_RDV_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdv_q |-> !busy_q && !wr_q); // R6
endmodule

// File: rtl/mdio_mgmt_regs.sv
`timescale 1ns/1ps
module mdio_mgmt_regs import mdio_mgmt_pkg::*; #(
  parameter int unsigned      DIV_W   = 4,
  parameter logic [DIV_W-1:0] DIV_RST = 'hD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              start_o,
  output mdio_req_t         req_o,
  output logic [DIV_W-1:0]  div_sel_o
);
  localparam int unsigned CFG_LSB = 2;
  localparam int unsigned PHY_LSB = 8;

  logic [DIV_W-1:0]   sel_q;
  logic [1:0]         cmd_q;
  logic               cmd_prev_q;
  logic [FIELD_W-1:0] phy_q, regn_q;
  logic [DATA_W-1:0]  wdat_q, rdat_q;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[31:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= DIV_RST;
      cmd_q      <= '0;
      cmd_prev_q <= 1'b0;
      phy_q      <= '0;
      regn_q     <= '0;
      wdat_q     <= '0;
      rdat_q     <= '0;
    end else begin
      cmd_prev_q <= cmd_q[0];
      if (rd_valid_i) rdat_q <= rd_data_i;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          OFS_CFG: sel_q  <= reg_wdata_i[CFG_LSB +: DIV_W];
          OFS_CMD: cmd_q  <= reg_wdata_i[1:0];
          OFS_ADR: begin
            phy_q  <= reg_wdata_i[PHY_LSB +: FIELD_W];
            regn_q <= reg_wdata_i[FIELD_W-1:0];
          end
          OFS_WDT: wdat_q <= reg_wdata_i[DATA_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // edge of the level command; a rise while busy is lost on purpose
  assign start_o   = cmd_q[0] && !cmd_prev_q && !busy_i;
  assign req_o     = '{wr: cmd_q[1], phy: phy_q, regn: regn_q, wdata: wdat_q};
  assign div_sel_o = sel_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CFG: reg_rdata_o = 32'(sel_q) << CFG_LSB;
      OFS_CMD: reg_rdata_o = {29'b0, busy_i, cmd_q};
      OFS_ADR: reg_rdata_o = (32'(phy_q) << PHY_LSB) | 32'(regn_q);
      OFS_WDT: reg_rdata_o = 32'(wdat_q);
      OFS_RDT: reg_rdata_o = 32'(rdat_q);
      default: reg_rdata_o = '0;
    endcase
  end

  AST_ONE_CYCLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_valid_i) && !rd_valid_i |=> $stable(rdat_q)); // R6
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl import mdio_mgmt_pkg::*; #(
  parameter int unsigned      DIV_W   = 4,
  parameter logic [DIV_W-1:0] DIV_RST = 'hD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              start, busy, tick, rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [DIV_W-1:0]  div_sel;
  mdio_req_t         req;

  mdio_mgmt_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .start_o(start), .req_o(req), .div_sel_o(div_sel)
  );

  mdio_mgmt_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .en_i(busy), .sel_i(div_sel), .tick_o(tick)
  );

  mdio_mgmt_frame u_frame (
    .clk_i, .rst_ni, .start_i(start), .req_i(req), .tick_i(tick),
    .mdio_i, .busy_o(busy), .mdc_o, .mdio_o, .mdio_oe_o,
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy); // R7
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  import mdio_mgmt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  mdio_mgmt_ctrl dut (
    .clk_i(clk), .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .mdc_o, .mdio_o, .mdio_oe_o, .mdio_i
  );

  always #10 clk = ~clk;

  // fields: [46] wr, [45:41] phy, [40:36] reg, [35:20] wdata, [19:4] phy reply, [3:0] sel
  localparam int NV = 5;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 4'd1},
    {1'b0, 5'd1,  5'd0,  16'h0000, 16'h1234, 4'd1},
    {1'b0, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 4'd0},
    {1'b1, 5'd0,  5'd17, 16'h0001, 16'h0000, 4'd0},
    {1'b0, 5'd9,  5'd2,  16'h0000, 16'h8001, 4'hD}
  };

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [15:0] cur_rsp = '0;
  int          idx = 0;
  logic        cap_d [64];
  logic        cap_oe [64];
  time         t0, t1;
  int          hold_viol = 0;
  logic        prev_mdc = 1'b0, prev_mdio = 1'b1, prev_oe = 1'b0;

  function automatic logic phy_bit(input int i);
    if (i >= 48 && i < 64) return cur_rsp[63-i];
    if (i == 47) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge mdc_o) begin
    if (idx < 64) begin
      cap_d[idx]  = mdio_o;
      cap_oe[idx] = mdio_oe_o;
    end
    if (idx == 0) t0 = $time;
    if (idx == 1) t1 = $time;
    idx = idx + 1;
  end

  always @(negedge mdc_o) mdio_i = phy_bit(idx);

  always @(negedge clk) begin
    if (rst_ni && prev_mdc && mdc_o && (mdio_o != prev_mdio || mdio_oe_o != prev_oe))
      hold_viol++;
    prev_mdc  = mdc_o;
    prev_mdio = mdio_o;
    prev_oe   = mdio_oe_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int k = 0; k < 6000; k++) begin
      rd_reg(OFS_CMD, r);
      if (!r[2]) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  logic [15:0] last_rd = '0;

  task automatic run_txn(input logic [46:0] v);
    logic        wr;
    logic [4:0]  p, r;
    logic [15:0] wd;
    logic [3:0]  sel;
    logic [31:0] rv;
    logic [63:0] ef;
    int          mism;
    wr = v[46]; p = v[45:41]; r = v[40:36]; wd = v[35:20]; sel = v[3:0];
    cur_rsp = v[19:4];
    wr_reg(OFS_CFG, 32'(sel) << 2);
    wr_reg(OFS_ADR, (32'(p) << 8) | 32'(r));
    wr_reg(OFS_WDT, 32'(wd));
    idx = 0; mdio_i = phy_bit(0);
    wr_reg(OFS_CMD, {30'b0, wr, 1'b1});
    repeat (6) @(negedge clk);
    rd_reg(OFS_CMD, rv);
    chk(rv[2] == 1'b1, "R7 busy during frame", 64'(rv[2]), 64'd1);
    wait_idle();
    chk(idx == 64, "R9 rising MDC count", 64'(idx), 64'd64);
    chk((t1 - t0) == time'(40 * (int'(sel) + 1)), "R3 MDC period", 64'(t1 - t0),
        64'(40 * (int'(sel) + 1)));
    ef = exp_frame(wr, p, r, wd);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      if (wr || i < 46) begin
        if (!cap_oe[i] || cap_d[i] !== ef[63-i]) mism++;
      end else if (cap_oe[i] !== 1'b0) mism++;
    end
    chk(mism == 0, wr ? "R4 write frame bits" : "R5 read frame bits and release", 64'(mism), 64'd0);
    repeat (30) @(negedge clk);
    chk(idx == 64, "R2 held command starts nothing", 64'(idx), 64'd64);
    wr_reg(OFS_CMD, 32'h0);
    repeat (3) @(negedge clk);
    rd_reg(OFS_RDT, rv);
    if (!wr) last_rd = cur_rsp;
    chk(rv == 32'(last_rd), wr ? "R6 write leaves read data" : "R6 read data captured",
        64'(rv), 64'(last_rd));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd_reg(OFS_CFG, rv); chk(rv == 32'h34, "R1 reset divider select", 64'(rv), 64'h34);
    rd_reg(OFS_CMD, rv); chk(rv == 32'h0, "R1 reset command", 64'(rv), 64'h0);
    rd_reg(OFS_RDT, rv); chk(rv == 32'h0, "R1 reset read data", 64'(rv), 64'h0);
    chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R3 idle MDC low and released",
        64'({mdc_o, mdio_oe_o}), 64'h0);

    // field positions
    wr_reg(OFS_ADR, 32'hFFFF_FFFF);
    rd_reg(OFS_ADR, rv); chk(rv == 32'h1F1F, "R1 address fields", 64'(rv), 64'h1F1F);
    wr_reg(OFS_WDT, 32'hDEAD_BEEF);
    rd_reg(OFS_WDT, rv); chk(rv == 32'hBEEF, "R1 write data field", 64'(rv), 64'hBEEF);
    wr_reg(OFS_CFG, 32'hFFFF_FFC3);
    rd_reg(OFS_CFG, rv); chk(rv == 32'h0, "R1 divider field only", 64'(rv), 64'h0);
    rd_reg(8'h90, rv); chk(rv == 32'h0, "R1 unmapped offset", 64'(rv), 64'h0);

    for (int v = 0; v < NV; v++) run_txn(VEC[v]);

    // command re-raised mid-frame must be ignored
    cur_rsp = 16'h0;
    wr_reg(OFS_CFG, 32'(4'd1) << 2);
    wr_reg(OFS_ADR, 32'h0305);
    wr_reg(OFS_WDT, 32'h5A5A);
    idx = 0; mdio_i = 1'b1;
    wr_reg(OFS_CMD, 32'h3);
    repeat (40) @(negedge clk);
    wr_reg(OFS_CMD, 32'h2);
    wr_reg(OFS_CMD, 32'h3);
    wait_idle();
    repeat (200) @(negedge clk);
    chk(idx == 64, "R2 rise during busy ignored", 64'(idx), 64'd64);
    rd_reg(OFS_CMD, rv);
    chk(rv[2] == 1'b0, "R7 busy low after frame", 64'(rv[2]), 64'd0);
    chk(mdc_o == 1'b0, "R3 MDC low after frame", 64'(mdc_o), 64'd0);
    wr_reg(OFS_CMD, 32'h0);

    chk(hold_viol == 0, "R8 MDIO stable while MDC high", 64'(hold_viol), 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule